// File: doc/BRIEF.md
# Register-Mapped Peripheral and Core Reset Controller

This block gives software one place to hold processor cores off and to kick peripherals back to their reset state. A plain 32-bit register bus reaches a small bank of word-aligned reset registers. The bus has a byte address, a write strobe, write data and read data. Some registers control a pair of processor cores. One register controls the whole group of DMA channels. Each remaining register controls a single peripheral, except a few spare registers that drive nothing.

Peripheral resets react to a change of the stored control bit, never to its level. When a write flips bit 0 of a peripheral register, in either direction, every target of that register receives a reset pulse lasting `PULSE_LEN` clock cycles. A write that leaves bit 0 alone does nothing beyond storing the word. Core resets are levels. A 1 in a core bit holds that core off. A 0 releases the core, which then starts again from its reset state.

The word index is the byte address divided by four. The map is laid out in this order:
- processor-pair registers at indices `0 .. NUM_CPU_REGS-1`;
- the DMA register at `NUM_CPU_REGS`;
- single-target peripheral registers next;
- spare registers last.

Top module: `rstctl_top`

## Requirements
- R1: After reset, every processor-pair register reads 0x00010303. Every DMA, peripheral and spare register reads 0x00000001. All `core_rst` bits are 1, and `dma_rst` and `periph_rst` are 0.
- R2: In a processor-pair register, only bits 0, 1, 8, 9 and 16 are writable. The other bits (mask 0xfffefcfc) always read 0. In every other register, only bit 0 is writable, and bits 31..1 read 0.
- R3: A write to a peripheral or DMA register whose bit 0 equals the stored bit 0 creates no reset pulse.
- R4: A write that changes bit 0 of a peripheral register creates a pulse on its output. The pulse goes high in the cycle after the write edge, stays high for exactly `PULSE_LEN` cycles and is the same for a 0-to-1 or a 1-to-0 change.
- R5: A write that changes bit 0 of the DMA register pulses every `dma_rst` bit together, with the same timing as R4. Single-target registers never touch `dma_rst`.
- R6: The peripheral register at word index `NUM_CPU_REGS+1+k` drives `periph_rst[k]` and no other output.
- R7: Processor-pair register j drives `core_rst[2j]` from its bit 0 and `core_rst[2j+1]` from its bit 1. Each output is a level that takes the written value in the cycle after the write and holds it otherwise.
- R8: A write to a spare register only stores bit 0. A write to an index past the last register, or to an address whose bits 1:0 are not 00, has no effect. Reads of such addresses return 0.
- R9: A change of bit 0 while that target's pulse is still active restarts the pulse at full length `PULSE_LEN`.
- R10: A synchronous global reset, taken while pulses run, restores every register to its R1 value. On the following edge it clears all pulses and sets every core bit. No pulse appears when the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous global reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_rst | output | 2*NUM_CPU_REGS | Per-core hold-off level, 1 = held in reset |
| dma_rst | output | NUM_DMA | Reset pulse to each DMA channel |
| periph_rst | output | NUM_PERIPH | Reset pulse to each single-target peripheral |

## Verification
The bench builds the block with:
- two processor-pair registers;
- three DMA channels;
- three peripherals;
- two spare registers;
- a 6-bit address;
- a pulse length of 3.

That configuration leaves eight of the sixteen word indices unmapped. The bench sweeps every index, mapped or not, with a set of patterns chosen so that bit 0 and the core bits are both repeated and flipped. After every write it compares each pulse output cycle by cycle against a per-target countdown, and reads back all sixteen words plus a misaligned alias of each. The short pulse length puts retriggering inside an active pulse, and a reset in the middle of a pulse, within a few cycles.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  typedef logic [31:0] word_t;

  // processor-pair register: reserved bits and power-up value
  localparam word_t CPU_RSVD    = 32'hfffe_fcfc;
  localparam word_t CPU_WMASK   = ~CPU_RSVD;
  localparam word_t CPU_RST_VAL = 32'h0001_0303;

  // single-bit registers power up asserted
  localparam logic  DEV_RST_VAL = 1'b1;

  localparam int CORES_PER_REG = 2;
endpackage

// File: rtl/rstctl_pulse.sv
module rstctl_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;

  // a new fire reloads the full length, including mid-pulse
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (fire)       cnt <= CW'(LEN);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/rstctl_dev_reg.sv
module rstctl_dev_reg
  import rstctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  output logic q,
  output logic flip
);
  // edge detect against the stored bit, same cycle as the update
  assign flip = wr && (wbit != q);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= DEV_RST_VAL;
    else if (wr) q <= wbit;
  end
endmodule

// File: rtl/rstctl_cpu_reg.sv
module rstctl_cpu_reg
  import rstctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  word_t                    wdata,
  output word_t                    q,
  output logic [CORES_PER_REG-1:0] hold
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= CPU_RST_VAL;
    else if (wr) q <= wdata & CPU_WMASK;
  end

  // each core bit is its own level; a 1->0 change releases that core only
  assign hold = q[CORES_PER_REG-1:0];
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int NUM_CPU_REGS = 2,
  parameter int NUM_DMA      = 4,
  parameter int NUM_PERIPH   = 4,
  parameter int NUM_SPARE    = 2,
  parameter int PULSE_LEN    = 4,
  parameter int ADDR_W       = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              bus_we,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  output logic [NUM_CPU_REGS*CORES_PER_REG-1:0] core_rst,
  output logic [NUM_DMA-1:0]                dma_rst,
  output logic [NUM_PERIPH-1:0]             periph_rst
);
  localparam int WORD_W     = ADDR_W - 2;
  localparam int NDEV       = 1 + NUM_PERIPH;      // DMA register + peripherals
  localparam int DEV_BASE   = NUM_CPU_REGS;
  localparam int SPARE_BASE = DEV_BASE + NDEV;

  logic              aligned;
  logic [WORD_W-1:0] word;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign word    = bus_addr[ADDR_W-1:2];

  // processor-pair registers
  word_t                   cpu_q [NUM_CPU_REGS];
  logic [NUM_CPU_REGS-1:0] cpu_sel;

  for (genvar j = 0; j < NUM_CPU_REGS; j++) begin : g_cpu
    assign cpu_sel[j] = aligned && (word == WORD_W'(j));
    rstctl_cpu_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_we && cpu_sel[j]),
      .wdata (bus_wdata),
      .q     (cpu_q[j]),
      .hold  (core_rst[j*CORES_PER_REG +: CORES_PER_REG])
    );
  end

  // single-bit registers with targets: index 0 is DMA, 1.. are peripherals
  logic [NDEV-1:0] dev_sel, dev_q, dev_flip;

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    assign dev_sel[i] = aligned && (word == WORD_W'(DEV_BASE + i));
    rstctl_dev_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_we && dev_sel[i]),
      .wbit  (bus_wdata[0]),
      .q     (dev_q[i]),
      .flip  (dev_flip[i])
    );
  end

  // DMA fan-out: one counter, replicated output
  logic dma_active;

  rstctl_pulse #(.LEN(PULSE_LEN)) u_dma_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (dev_flip[0]),
    .active (dma_active)
  );
  assign dma_rst = {NUM_DMA{dma_active}};

  for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_per
    rstctl_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (dev_flip[1+k]),
      .active (periph_rst[k])
    );
  end

  // spare registers: storage only, no target
  logic [NUM_SPARE-1:0] sp_sel, sp_q;

  for (genvar s = 0; s < NUM_SPARE; s++) begin : g_sp
    assign sp_sel[s] = aligned && (word == WORD_W'(SPARE_BASE + s));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp_q <= {NUM_SPARE{DEV_RST_VAL}};
    else begin
      for (int s = 0; s < NUM_SPARE; s++)
        if (bus_we && sp_sel[s]) sp_q[s] <= bus_wdata[0];
    end
  end

  // read mux: unmapped or misaligned addresses return zero
  always_comb begin
    bus_rdata = '0;
    for (int j = 0; j < NUM_CPU_REGS; j++)
      if (cpu_sel[j]) bus_rdata = cpu_q[j];
    for (int i = 0; i < NDEV; i++)
      if (dev_sel[i]) bus_rdata = {31'b0, dev_q[i]};
    for (int s = 0; s < NUM_SPARE; s++)
      if (sp_sel[s]) bus_rdata = {31'b0, sp_q[s]};
  end
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk
  import rstctl_pkg::*;
#(
  parameter int NUM_CPU_REGS = 2,
  parameter int NUM_DMA      = 4,
  parameter int NUM_PERIPH   = 4,
  parameter int NUM_SPARE    = 2,
  parameter int PULSE_LEN    = 4,
  parameter int ADDR_W       = 8
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [ADDR_W-1:0]                 bus_addr,
  input logic                              bus_we,
  input logic [31:0]                       bus_wdata,
  input logic [31:0]                       bus_rdata,
  input logic [NUM_CPU_REGS*CORES_PER_REG-1:0] core_rst,
  input logic [NUM_DMA-1:0]                dma_rst,
  input logic [NUM_PERIPH-1:0]             periph_rst
);
  localparam int NREG   = NUM_CPU_REGS + 1 + NUM_PERIPH + NUM_SPARE;
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] DMA_ADDR = ADDR_W'(NUM_CPU_REGS * 4);

  // R10: on the edge after a sampled reset, outputs match reset values
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= !rst_n;

  always @(negedge clk) begin
    if (rst_seen == 1'b1) begin
      a_r10_reset_outputs: assert (core_rst == '1 && dma_rst == '0 && periph_rst == '0)
        else $error("reset did not restore outputs");
    end
  end

  // R8: misaligned and out-of-range reads are zero
  a_r8_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));
  a_r8_past_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, bus_addr[ADDR_W-1:2]} >= (WORD_W+1)'(NREG)) |-> (bus_rdata == '0));

  // R5: DMA bit change pulses every channel next cycle
  a_r5_dma_fanout: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == DMA_ADDR && bus_wdata[0] != bus_rdata[0]) |=> (dma_rst == '1));

  // R2: single-bit registers read zero above bit 0
  a_r2_dma_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DMA_ADDR) |-> (bus_rdata[31:1] == '0));

  for (genvar j = 0; j < NUM_CPU_REGS; j++) begin : g_cpu_chk
    localparam logic [ADDR_W-1:0] A = ADDR_W'(j * 4);
    a_r2_cpu_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A) |-> ((bus_rdata & CPU_RSVD) == '0));
    a_r7_core_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A) |=> (core_rst[j*2 +: 2] == $past(bus_wdata[1:0])));
    a_r7_core_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == A) |=> $stable(core_rst[j*2 +: 2]));
  end

  for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_per_chk
    localparam logic [ADDR_W-1:0] A = ADDR_W'((NUM_CPU_REGS + 1 + k) * 4);
    a_r4_flip_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A && bus_wdata[0] != bus_rdata[0]) |=> periph_rst[k]);
    a_r3_same_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A && bus_wdata[0] == bus_rdata[0] && !periph_rst[k])
        |=> !periph_rst[k]);
    a_r6_rise_needs_own_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(periph_rst[k]) |-> $past(bus_we && bus_addr == A));
  end
endmodule

bind rstctl_top rstctl_chk #(
  .NUM_CPU_REGS (NUM_CPU_REGS),
  .NUM_DMA      (NUM_DMA),
  .NUM_PERIPH   (NUM_PERIPH),
  .NUM_SPARE    (NUM_SPARE),
  .PULSE_LEN    (PULSE_LEN),
  .ADDR_W       (ADDR_W)
) u_chk (.*);

// File: tb/tb_rstctl_top.sv
module tb_rstctl_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NC = 2, ND = 3, NP = 3, NS = 2, PL = 3, AW = 6;
  localparam int NREG = NC + 1 + NP + NS;
  localparam int NW = 1 << (AW - 2);
  localparam int NCORE = 2 * NC;

  logic             clk, rst_n, bus_we;
  logic [AW-1:0]    bus_addr;
  logic [31:0]      bus_wdata, bus_rdata;
  logic [NCORE-1:0] core_rst;
  logic [ND-1:0]    dma_rst;
  logic [NP-1:0]    periph_rst;

  rstctl_top #(.NUM_CPU_REGS(NC), .NUM_DMA(ND), .NUM_PERIPH(NP),
               .NUM_SPARE(NS), .PULSE_LEN(PL), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_rst(core_rst),
    .dma_rst(dma_rst), .periph_rst(periph_rst));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  logic [31:0] m_reg [NW];
  int p_dma;
  int p_per [NP];

  // 0 cpu pair, 1 dma, 2 peripheral, 3 spare, 4 unmapped
  function automatic int kind(int w);
    if (w < NC) return 0;
    if (w == NC) return 1;
    if (w < NC + 1 + NP) return 2;
    if (w < NREG) return 3;
    return 4;
  endfunction

  function automatic logic [31:0] wmask(int w);
    case (kind(w))
      0: return 32'h0001_0303;
      4: return 32'h0;
      default: return 32'h1;
    endcase
  endfunction

  function automatic logic [31:0] rval(int w);
    return (kind(w) == 0) ? 32'h0001_0303 : ((kind(w) == 4) ? 32'h0 : 32'h1);
  endfunction

  task automatic model_reset();
    for (int w = 0; w < NW; w++) m_reg[w] = rval(w);
    p_dma = 0;
    for (int k = 0; k < NP; k++) p_per[k] = 0;
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    logic [NP-1:0]    ep;
    logic [NCORE-1:0] ec;
    for (int k = 0; k < NP; k++) ep[k] = (p_per[k] > 0);
    for (int j = 0; j < NC; j++) ec[2*j +: 2] = m_reg[j][1:0];
    chk(tag, "dma_rst", 32'(dma_rst), (p_dma > 0) ? 32'(ND'('1)) : 32'h0);
    chk(tag, "periph_rst (R6 index map)", 32'(periph_rst), 32'(ep));
    chk(tag, "core_rst", 32'(core_rst), 32'(ec));
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input bit w, input int a, input logic [31:0] d, input string tag);
    int wi;
    logic [31:0] nv;
    bus_we = w; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    if (p_dma > 0) p_dma--;
    for (int k = 0; k < NP; k++) if (p_per[k] > 0) p_per[k]--;
    if (w && (a % 4 == 0) && (a / 4 < NREG)) begin
      wi = a / 4;
      nv = d & wmask(wi);
      if (kind(wi) == 1 && nv[0] != m_reg[wi][0]) p_dma = PL;
      if (kind(wi) == 2 && nv[0] != m_reg[wi][0]) p_per[wi-NC-1] = PL;
      m_reg[wi] = nv;
    end
    bus_we = 1'b0;
    check_outputs(tag);
  endtask

  task automatic readall(input string tag);
    for (int w = 0; w < NW; w++) begin
      bus_addr = AW'(w * 4);
      #0.05;
      chk(tag, $sformatf("read word %0d", w), bus_rdata, m_reg[w]);
      bus_addr = AW'(w * 4 + 1);
      #0.05;
      chk("R8", $sformatf("misaligned read word %0d", w), bus_rdata, 32'h0);
    end
  endtask

  function automatic string tag_for(int w, logic [31:0] d);
    case (kind(w))
      0: return "R7";
      1: return (d[0] != m_reg[w][0]) ? "R5" : "R3";
      2: return (d[0] != m_reg[w][0]) ? "R4" : "R3";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL R1 watchdog: actual=no completion expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_0000;
    pats[3] = 32'h0000_0000; pats[4] = 32'hA5A5_A5A5; pats[5] = 32'h5A5A_5A5A;

    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    model_reset();
    check_outputs("R1");
    readall("R1");
    rst_n = 1'b1;

    // sweep every word index with every pattern (R2..R8)
    for (int w = 0; w < NW; w++) begin
      for (int p = 0; p < 6; p++) begin
        string t;
        t = tag_for(w, pats[p]);
        step(1'b1, w * 4, pats[p], t);
        repeat (PL + 1) step(1'b0, 0, 32'h0, t);
        readall("R2");
      end
    end

    // misaligned writes are ignored (R8)
    for (int w = 0; w < NREG; w++) begin
      step(1'b1, w * 4 + 2, ~m_reg[w], "R8");
      repeat (PL + 1) step(1'b0, 0, 32'h0, "R8");
    end
    readall("R8");

    // retrigger mid-pulse (R9)
    step(1'b1, (NC + 2) * 4, ~m_reg[NC+2], "R9");
    step(1'b0, 0, 32'h0, "R9");
    step(1'b1, (NC + 2) * 4, ~m_reg[NC+2], "R9");
    repeat (PL + 1) step(1'b0, 0, 32'h0, "R9");
    step(1'b1, NC * 4, ~m_reg[NC], "R9");
    step(1'b1, NC * 4, ~m_reg[NC], "R9");
    repeat (PL + 1) step(1'b0, 0, 32'h0, "R9");

    // global reset during active pulses (R10)
    step(1'b1, 0, 32'h0, "R10");
    step(1'b1, NC * 4, ~m_reg[NC], "R10");
    step(1'b1, (NC + 1) * 4, ~m_reg[NC+1], "R10");
    rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    check_outputs("R10");
    readall("R10");
    rst_n = 1'b1;
    repeat (PL + 2) step(1'b0, 0, 32'h0, "R10");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule